// File: doc/BRIEF.md
# Power-Up Start Sequencer

This block decides where a 16-bit minicomputer core starts running once reset is released. In the first cycle after reset it takes one sample of a two-bit start-option code, a fixed-boot select and seven boot-address configuration bits. From that sample it picks one of four start actions:

- read a new program counter (PC) and processor status word (PS) from a vector in low memory,
- go straight to the console monitor,
- load the PC from a boot address built from the configuration bits,
- jump to an optional extended start routine. When that routine is absent, it traps through a fixed vector instead.

The block reads memory one word at a time through a request/acknowledge port that has a timeout. It shows its result on PC/PS outputs, with a one-cycle load strobe and sticky done and console flags.

Once the program is running, the block also handles a halt request. Depending on a halt-enable input, the request either stops the core for good or traps through a low vector. The trap uses the same two-word read as the power-up vector fetch.

Top module: `ps_start_seq`

## Requirements
- R1: While reset is high, and in the cycle it is released, all of these outputs are 0: mem_req, load_pc, done, console_mode, timeout_err and halted. pc_out and ps_out are also 0.
- R2: With option code 2'b00, the block reads address 16'h0014 (octal 024) first, then 16'h0016 (octal 026), and makes no other reads. It loads PC from the first word and PS from the second, then raises load_pc.
- R3: With option code 2'b01, the block makes no read and raises no load strobe. It sets console_mode and done, and both stay set.
- R4: With option code 2'b10, PC becomes the boot address and PS stays 0. When fixed_boot is 1, the boot address is 16'hF600 (octal 0173000). Otherwise bit 15-9 of the address equal boot_cfg[6:0], with boot_cfg[6] going to bit 15, and bits 8-0 are 0.
- R5: With option code 2'b11 and ext_present high, PC becomes parameter EXT_START and PS stays 0. With ext_present low, the block reads a new PC from 16'h0008 and a new PS from 16'h000A.
- R6: The option code and the configuration inputs are used only in the first cycle after reset. Changes after that cycle have no effect on the start sequence.
- R7: If a read gets no mem_ack for TIMEOUT_CYC cycles, the block drops the request and sets timeout_err and console_mode. It then makes no load.
- R8: load_pc is high for exactly one cycle for each PC load. done rises in the cycle after that strobe and stays high until reset.
- R9: A halt_req while running with halt_en high sets halted. After that the block makes no further read or load.
- R10: A halt_req while running with halt_en low reads a new PC from 16'h0004 and a new PS from 16'h0006, then pulses load_pc again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_code | input | 2 | Start-option code |
| fixed_boot | input | 1 | Selects the fixed boot address |
| boot_cfg | input | 7 | Boot address bits 15..9 |
| ext_present | input | 1 | Extended start routine is installed |
| halt_en | input | 1 | 1: halt stops, 0: halt traps |
| halt_req | input | 1 | Halt request |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 16 | Read data |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read word address |
| pc_out | output | 16 | Program counter to load |
| ps_out | output | 16 | Status word to load |
| load_pc | output | 1 | One-cycle PC/PS load strobe |
| done | output | 1 | Start sequence complete |
| console_mode | output | 1 | Console monitor entry |
| timeout_err | output | 1 | A read timed out |
| halted | output | 1 | Core stopped by halt |

## Verification
The assertions assume three things about the inputs:
- mem_ack is only high in cycles where mem_req is high.
- halt_req only matters once the core is running.
- reset is held for at least one clock.

The bench's memory model only raises acknowledge while a request is pending, and drops it for one cycle after each accepted word. Halt requests are driven only after done has been seen, and every scenario begins with a reset held for three cycles.

// File: rtl/ps_start_pkg.sv
package ps_start_pkg;

    localparam int WORD_W = 16;
    localparam int CFG_W  = 7;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_RD_PC,
        ST_RD_PS,
        ST_LOAD,
        ST_RUN,
        ST_CONSOLE,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        OPT_VECTOR   = 2'b00,
        OPT_CONSOLE  = 2'b01,
        OPT_JUMPER   = 2'b10,
        OPT_EXTENDED = 2'b11
    } start_opt_e;

    localparam logic [WORD_W-1:0] VEC_POWERUP = 16'o000024;
    localparam logic [WORD_W-1:0] VEC_NOEXT   = 16'o000010;
    localparam logic [WORD_W-1:0] VEC_HALT    = 16'o000004;
    localparam logic [WORD_W-1:0] FIXED_BOOT  = 16'o173000;

    function automatic logic [WORD_W-1:0] second_word(input logic [WORD_W-1:0] vec);
        return vec + WORD_W'(2);
    endfunction

endpackage

// File: rtl/ps_boot_addr.sv
module ps_boot_addr
    import ps_start_pkg::*;
#(
    parameter int AW = WORD_W,
    parameter int CW = CFG_W
) (
    input  logic          fixed_sel,
    input  logic [CW-1:0] cfg,
    output logic [AW-1:0] addr
);
    localparam int LOW_W = AW - CW;

    always_comb begin
        if (fixed_sel) addr = AW'(FIXED_BOOT);
        else           addr = {cfg, {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/ps_read_timer.sv
module ps_read_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || clear) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && !clear && (cnt_q == LAST);
endmodule

// File: rtl/ps_start_seq.sv
module ps_start_seq
    import ps_start_pkg::*;
#(
    parameter int                TIMEOUT_CYC = 16,
    parameter logic [WORD_W-1:0] EXT_START   = 16'o140000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        opt_code,
    input  logic              fixed_boot,
    input  logic [CFG_W-1:0]  boot_cfg,
    input  logic              ext_present,
    input  logic              halt_en,
    input  logic              halt_req,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] ps_out,
    output logic              load_pc,
    output logic              done,
    output logic              console_mode,
    output logic              timeout_err,
    output logic              halted
);
    seq_state_e        state_q;
    logic [WORD_W-1:0] pc_q, ps_q, vec_q, boot_addr;
    logic              done_q, err_q, expired;

    ps_boot_addr #(.AW(WORD_W), .CW(CFG_W)) u_addr (
        .fixed_sel (fixed_boot),
        .cfg       (boot_cfg),
        .addr      (boot_addr)
    );

    ps_read_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (mem_req),
        .clear   (mem_ack),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SAMPLE;
            pc_q    <= '0;
            ps_q    <= '0;
            vec_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SAMPLE: begin
                    unique case (start_opt_e'(opt_code))
                        OPT_VECTOR: begin
                            vec_q   <= VEC_POWERUP;
                            state_q <= ST_RD_PC;
                        end
                        OPT_CONSOLE: begin
                            done_q  <= 1'b1;
                            state_q <= ST_CONSOLE;
                        end
                        OPT_JUMPER: begin
                            pc_q    <= boot_addr;
                            state_q <= ST_LOAD;
                        end
                        OPT_EXTENDED: begin
                            if (ext_present) begin
                                pc_q    <= EXT_START;
                                state_q <= ST_LOAD;
                            end else begin
                                vec_q   <= VEC_NOEXT;
                                state_q <= ST_RD_PC;
                            end
                        end
                    endcase
                end
                ST_RD_PC: begin
                    if (mem_ack) begin
                        pc_q    <= mem_rdata;
                        state_q <= ST_RD_PS;
                    end else if (expired) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_CONSOLE;
                    end
                end
                ST_RD_PS: begin
                    if (mem_ack) begin
                        ps_q    <= mem_rdata;
                        state_q <= ST_LOAD;
                    end else if (expired) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_CONSOLE;
                    end
                end
                ST_LOAD: begin
                    done_q  <= 1'b1;
                    state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (halt_req) begin
                        if (halt_en) begin
                            state_q <= ST_HALT;
                        end else begin
                            vec_q   <= VEC_HALT;
                            state_q <= ST_RD_PC;
                        end
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign mem_req      = (state_q == ST_RD_PC) || (state_q == ST_RD_PS);
    assign mem_addr     = (state_q == ST_RD_PS) ? second_word(vec_q) : vec_q;
    assign load_pc      = (state_q == ST_LOAD);
    assign pc_out       = pc_q;
    assign ps_out       = ps_q;
    assign done         = done_q;
    assign console_mode = (state_q == ST_CONSOLE);
    assign timeout_err  = err_q;
    assign halted       = (state_q == ST_HALT);
endmodule

// File: rtl/ps_start_seq_chk.sv
module ps_start_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        load_pc,
    input logic        done,
    input logic        console_mode,
    input logic        timeout_err,
    input logic        halted
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        load_pc |=> !load_pc);

    assert_done_after_load_R8: assert property (@(posedge clk) disable iff (rst)
        load_pc |=> done);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_console_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        console_mode |=> console_mode);

    assert_console_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        console_mode |-> (!mem_req && !load_pc && done));

    assert_err_console_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> console_mode);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_req && !load_pc));

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (!mem_addr[0] && !load_pc));
endmodule

bind ps_start_seq ps_start_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .load_pc      (load_pc),
    .done         (done),
    .console_mode (console_mode),
    .timeout_err  (timeout_err),
    .halted       (halted)
);

// File: tb/ps_start_seq_tb.sv
module ps_start_seq_tb;
    localparam int          TMO     = 16;
    localparam logic [15:0] EXT_ADR = 16'o140000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  opt_code = 2'b00;
    logic        fixed_boot = 1'b0;
    logic [6:0]  boot_cfg = '0;
    logic        ext_present = 1'b0;
    logic        halt_en = 1'b0;
    logic        halt_req = 1'b0;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_req, load_pc, done, console_mode, timeout_err, halted;
    logic [15:0] mem_addr, pc_out, ps_out;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          lat      = 0;
    int          wait_cnt = 0;
    bit          mem_en   = 1'b1;
    int          rd_n     = 0;
    logic [15:0] rd_log [8];
    int          loads    = 0;

    always #2 clk = ~clk;

    ps_start_seq #(.TIMEOUT_CYC(TMO), .EXT_START(EXT_ADR)) u_dut (
        .clk(clk), .rst(rst), .opt_code(opt_code), .fixed_boot(fixed_boot),
        .boot_cfg(boot_cfg), .ext_present(ext_present), .halt_en(halt_en),
        .halt_req(halt_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .pc_out(pc_out), .ps_out(ps_out),
        .load_pc(load_pc), .done(done), .console_mode(console_mode),
        .timeout_err(timeout_err), .halted(halted)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0], 8'h5A} ^ 16'h1234;
    endfunction

    // Memory model and load monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (load_pc) loads++;
        if (!mem_en || !mem_req || mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (wait_cnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = memf(mem_addr);
            if (rd_n < 8) rd_log[rd_n] = mem_addr;
            rd_n++;
        end else begin
            wait_cnt++;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic start(input logic [1:0] opt, input logic fx, input logic [6:0] cfg,
                         input logic ext, input int latency, input bit en);
        rst = 1'b1; opt_code = opt; fixed_boot = fx; boot_cfg = cfg;
        ext_present = ext; lat = latency; mem_en = en; halt_req = 1'b0;
        tick(3);
        rd_n = 0; loads = 0;
        chk("R1 reset outputs",
            {10'b0, mem_req, load_pc, done, console_mode, timeout_err, halted}, 16'h0);
        chk("R1 reset pc", pc_out, 16'h0);
        rst = 1'b0;
    endtask

    task automatic wait_done(input int max);
        for (int i = 0; i < max && !done; i++) tick(1);
        tick(2);
    endtask

    task automatic t_vector();
        start(2'b00, 1'b0, 7'h00, 1'b0, 2, 1'b1);
        chk("R1 first cycle after release", {15'b0, mem_req | load_pc | done}, 16'h0);
        wait_done(60);
        chk("R2 read count", 16'(rd_n), 16'd2);
        chk("R2 first address", rd_log[0], 16'h0014);
        chk("R2 second address", rd_log[1], 16'h0016);
        chk("R2 pc", pc_out, memf(16'h0014));
        chk("R2 ps", ps_out, memf(16'h0016));
        chk("R8 one strobe", 16'(loads), 16'd1);
        tick(5);
        chk("R8 done sticky", {15'b0, done}, 16'h1);
    endtask

    task automatic t_console();
        start(2'b01, 1'b0, 7'h7F, 1'b1, 0, 1'b1);
        tick(6);
        chk("R3 console", {14'b0, console_mode, done}, 16'h3);
        chk("R3 no read/load", 16'(rd_n + loads), 16'd0);
        chk("R3 no error", {15'b0, timeout_err}, 16'h0);
    endtask

    task automatic t_jumper();
        start(2'b10, 1'b0, 7'b1010011, 1'b0, 0, 1'b1);
        wait_done(20);
        chk("R4 cfg address", pc_out, {7'b1010011, 9'b0});
        chk("R4 ps zero", ps_out, 16'h0);
        chk("R8 single strobe jumper", 16'(loads), 16'd1);
        start(2'b10, 1'b0, 7'h7F, 1'b0, 0, 1'b1);
        wait_done(20);
        chk("R4 all ones", pc_out, 16'hFE00);
        start(2'b10, 1'b1, 7'h00, 1'b0, 0, 1'b1);
        wait_done(20);
        chk("R4 fixed address", pc_out, 16'o173000);
        chk("R4 no reads", 16'(rd_n), 16'd0);
    endtask

    task automatic t_extended();
        start(2'b11, 1'b0, 7'h00, 1'b1, 0, 1'b1);
        wait_done(20);
        chk("R5 ext start", pc_out, EXT_ADR);
        chk("R5 ext no read", 16'(rd_n), 16'd0);
        start(2'b11, 1'b0, 7'h00, 1'b0, 1, 1'b1);
        wait_done(60);
        chk("R5 trap addr pc", rd_log[0], 16'h0008);
        chk("R5 trap addr ps", rd_log[1], 16'h000A);
        chk("R5 trap pc", pc_out, memf(16'h0008));
        chk("R5 trap ps", ps_out, memf(16'h000A));
    endtask

    task automatic t_sample_once();
        start(2'b00, 1'b0, 7'h00, 1'b0, 4, 1'b1);
        tick(1);
        opt_code = 2'b01; fixed_boot = 1'b1; boot_cfg = 7'h55; ext_present = 1'b1;
        wait_done(80);
        chk("R6 still vector reads", 16'(rd_n), 16'd2);
        chk("R6 still vector pc", pc_out, memf(16'h0014));
        chk("R6 not console", {15'b0, console_mode}, 16'h0);
    endtask

    task automatic t_timeout();
        start(2'b00, 1'b0, 7'h00, 1'b0, 0, 1'b0);
        tick(TMO - 2);
        chk("R7 still waiting", {14'b0, mem_req, console_mode}, 16'h2);
        tick(10);
        chk("R7 timeout flags", {13'b0, timeout_err, console_mode, mem_req}, 16'h6);
        chk("R7 no load", 16'(loads), 16'd0);
        mem_en = 1'b1;
    endtask

    task automatic t_halt_stop();
        start(2'b10, 1'b0, 7'h11, 1'b0, 0, 1'b1);
        wait_done(20);
        halt_en = 1'b1; halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
        tick(10);
        chk("R9 halted", {15'b0, halted}, 16'h1);
        chk("R9 no activity", 16'(rd_n * 16 + loads), 16'd1);
    endtask

    task automatic t_halt_trap();
        start(2'b10, 1'b0, 7'h11, 1'b0, 1, 1'b1);
        wait_done(20);
        halt_en = 1'b0; halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
        tick(20);
        chk("R10 read addr pc", rd_log[0], 16'h0004);
        chk("R10 read addr ps", rd_log[1], 16'h0006);
        chk("R10 pc", pc_out, memf(16'h0004));
        chk("R10 ps", ps_out, memf(16'h0006));
        chk("R10 second strobe", 16'(loads), 16'd2);
        chk("R10 not halted", {15'b0, halted}, 16'h0);
    endtask

    initial begin
        fork
            begin
                t_vector();
                t_console();
                t_jumper();
                t_extended();
                t_sample_once();
                t_timeout();
                t_halt_stop();
                t_halt_trap();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule